// File: doc/BRIEF.md
# Mixed-Radix Parallel-Prefix Adder

This block adds two unsigned operands of `WIDTH` bits (16 by default) and returns a `WIDTH`-bit sum together with a carry-out. It is purely combinational, and the carry-in is fixed at zero. The carries come from a parallel-prefix network built from two kinds of group cell. The first kind merges two adjacent groups of generate/propagate pairs. The second kind merges three adjacent groups in one step.

The cell type depends on bit position. The lowest quarter of the positions resolves its prefixes in a separate radix-2 doubling network made only of two-input cells, which keeps area low where the paths are short anyway. Every higher position resolves through a radix-3 tripling network. In that network a position uses a three-input cell when two earlier partial groups are still open, and a two-input cell when one merge is enough to reach bit 0. As a result the three-input cells gather toward the most significant end, where they shorten the critical path.

The block can be used directly inside an arithmetic datapath. To use it for timing experiments, place registers around it.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: Bit i of each operand gives generate g = a AND b and propagate p = a XOR b. Sum bit 0 equals op_a[0] XOR op_b[0].
- R2: For every pair of operands, {carry_out, sum} equals the (WIDTH+1)-bit unsigned value op_a + op_b. At WIDTH = 8 the result is a 9-bit value.
- R3: If both operand MSBs are 1, carry_out is 1. If both operand MSBs are 0, carry_out is 0.
- R4: Adding zero in either operand returns the other operand unchanged, with carry_out 0.
- R5: If every bit propagates (op_b = ~op_a), the sum is all ones and carry_out is 0. No group cell in the tree ever reports generate and propagate together over the same span.
- R6: All-ones plus all-ones gives carry_out 1 and a sum of all ones except bit 0, which is 0.
- R7: All-ones plus one gives carry_out 1 and a sum of zero. This is the longest carry path.
- R8: The alternating patterns give these results: 0x5555 + 0xAAAA = 0xFFFF with carry_out 0, and 0xAAAA + 0xAAAA = 0x5554 with carry_out 1 (16-bit values).
- R9: The outputs depend only on the present operands. A new operand pair is reflected on sum and carry_out with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Low WIDTH bits of op_a + op_b |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bound checker tests, on every operand change, the invariants that hold for any input: sum bit 0 against the operand LSBs, carry-out against MSB generate and kill, the zero identity, the full-propagate result, and the exclusivity of generate and propagate at every tree output. The exact sum for arbitrary operands, the long carry chains of all-ones and alternating patterns, and complete coverage of the 8-bit operand space are shown only by the bench. It compares a 16-bit instance against random and directed vectors and runs an 8-bit instance exhaustively.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a more significant group (hi) with the adjacent lower one (lo).
    function automatic gp_t gp_join2(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Merge three adjacent groups, hi being the most significant.
    function automatic gp_t gp_join3(input gp_t hi, input gp_t mid, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & mid.g) | (hi.p & mid.p & lo.g);
        r.p = hi.p & mid.p & lo.p;
        return r;
    endfunction

    // Number of tripling levels needed for a span to reach n.
    function automatic int unsigned ceil_log3(input int unsigned n);
        int unsigned span;
        int unsigned lv;
        span = 1;
        lv   = 0;
        while (span < n) begin
            span = span * 3;
            lv   = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/hpa_bitgen.sv
module hpa_bitgen #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]               op_a,
    input  logic [WIDTH-1:0]               op_b,
    output hpa_pkg::gp_t [WIDTH-1:0]       bit_gp
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_gp[i].g = op_a[i] & op_b[i];
        assign bit_gp[i].p = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/hpa_prefix_tree.sv
module hpa_prefix_tree #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned LOW_W = 4
) (
    input  hpa_pkg::gp_t [WIDTH-1:0] bit_gp,
    output hpa_pkg::gp_t [WIDTH-1:0] grp
);
    import hpa_pkg::*;

    localparam int unsigned L2 = (LOW_W > 1) ? $clog2(LOW_W) : 0;
    localparam int unsigned L3 = ceil_log3(WIDTH);

    // Low quarter: radix-2 doubling network, two-input cells only.
    gp_t [LOW_W-1:0] lo_net [L2+1];
    // Upper positions: radix-3 tripling network; low positions are fed in
    // as already-complete prefixes.
    gp_t [WIDTH-1:0] hi_net [L3+1];

    for (genvar j = 0; j < LOW_W; j++) begin : g_lo_in
        assign lo_net[0][j] = bit_gp[j];
    end

    for (genvar l = 0; l < L2; l++) begin : g_lo_lvl
        localparam int unsigned S = 2 ** l;
        for (genvar j = 0; j < LOW_W; j++) begin : g_lo_pos
            if (j < S) begin : g_pass
                assign lo_net[l+1][j] = lo_net[l][j];
            end else begin : g_cell2
                assign lo_net[l+1][j] = gp_join2(lo_net[l][j], lo_net[l][j-S]);
            end
        end
    end

    for (genvar j = 0; j < WIDTH; j++) begin : g_hi_in
        if (j < LOW_W) begin : g_done
            assign hi_net[0][j] = lo_net[L2][j];
        end else begin : g_raw
            assign hi_net[0][j] = bit_gp[j];
        end
    end

    for (genvar l = 0; l < L3; l++) begin : g_hi_lvl
        localparam int unsigned S = 3 ** l;
        for (genvar j = 0; j < WIDTH; j++) begin : g_hi_pos
            if (j < LOW_W) begin : g_low_hold
                assign hi_net[l+1][j] = lo_net[L2][j];
            end else if (j < S) begin : g_pass
                assign hi_net[l+1][j] = hi_net[l][j];
            end else if (j < 2 * S) begin : g_cell2
                assign hi_net[l+1][j] = gp_join2(hi_net[l][j], hi_net[l][j-S]);
            end else begin : g_cell3
                assign hi_net[l+1][j] = gp_join3(hi_net[l][j], hi_net[l][j-S],
                                                 hi_net[l][j-2*S]);
            end
        end
    end

    assign grp = hi_net[L3];
endmodule

// File: rtl/hpa_sum.sv
module hpa_sum #(
    parameter int unsigned WIDTH = 16
) (
    input  hpa_pkg::gp_t [WIDTH-1:0] bit_gp,
    input  hpa_pkg::gp_t [WIDTH-1:0] grp,
    output logic [WIDTH-1:0]         sum,
    output logic                     carry_out
);
    assign sum[0] = bit_gp[0].p;
    for (genvar i = 1; i < WIDTH; i++) begin : g_sum
        assign sum[i] = bit_gp[i].p ^ grp[i-1].g;
    end
    assign carry_out = grp[WIDTH-1].g;
endmodule

// File: rtl/hybrid_prefix_adder.sv
module hybrid_prefix_adder #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int unsigned LOW_W = (WIDTH / 4 < 1) ? 1 : WIDTH / 4;

    hpa_pkg::gp_t [WIDTH-1:0] bit_gp;
    hpa_pkg::gp_t [WIDTH-1:0] grp;

    hpa_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .op_a   (op_a),
        .op_b   (op_b),
        .bit_gp (bit_gp)
    );

    hpa_prefix_tree #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_tree (
        .bit_gp (bit_gp),
        .grp    (grp)
    );

    hpa_sum #(.WIDTH(WIDTH)) u_sum (
        .bit_gp    (bit_gp),
        .grp       (grp),
        .sum       (sum),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/hpa_checker.sv
module hpa_checker #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0]         op_a,
    input logic [WIDTH-1:0]         op_b,
    input logic [WIDTH-1:0]         sum,
    input logic                     carry_out,
    input hpa_pkg::gp_t [WIDTH-1:0] grp
);
    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            a_r1_sum_lsb: assert (sum[0] == (op_a[0] ^ op_b[0]))
                else $error("sum lsb mismatch");
            if (op_a[WIDTH-1] && op_b[WIDTH-1]) begin
                a_r3_msb_generate: assert (carry_out)
                    else $error("carry_out missing");
            end
            if (!op_a[WIDTH-1] && !op_b[WIDTH-1]) begin
                a_r3_msb_kill: assert (!carry_out)
                    else $error("carry_out spurious");
            end
            if (op_b == '0) begin
                a_r4_zero_identity: assert (!carry_out && sum == op_a)
                    else $error("zero identity broken");
            end
            if (op_b == ~op_a) begin
                a_r5_full_propagate: assert (!carry_out && sum == '1)
                    else $error("full propagate wrong");
            end
            for (int j = 0; j < WIDTH; j++) begin
                a_r5_gp_exclusive: assert (!(grp[j].g && grp[j].p))
                    else $error("group g and p both set at %0d", j);
            end
        end
    end
endmodule

bind hybrid_prefix_adder hpa_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .sum       (sum),
    .carry_out (carry_out),
    .grp       (grp)
);

// File: tb/hybrid_prefix_adder_tb.sv
module hybrid_prefix_adder_tb;
    localparam int unsigned W  = 16;
    localparam int unsigned W8 = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0]  a16, b16, s16;
    logic          c16;
    logic [W8-1:0] a8, b8, s8;
    logic          c8;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    hybrid_prefix_adder #(.WIDTH(W)) u_dut (
        .op_a(a16), .op_b(b16), .sum(s16), .carry_out(c16));

    hybrid_prefix_adder #(.WIDTH(W8)) u_dut8 (
        .op_a(a8), .op_b(b8), .sum(s8), .carry_out(c8));

    function automatic logic [W:0] ref16(input logic [W-1:0] x, input logic [W-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    function automatic logic [W8:0] ref8(input logic [W8-1:0] x, input logic [W8-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic chk16(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] exp;
        a16 = x;
        b16 = y;
        #1;
        exp = ref16(x, y);
        checks++;
        if ({c16, s16} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, {c16, s16}, exp);
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; a8 = '0; b8 = '0;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);

        // Reset-like idle state: zero operands give zero result (R4)
        chk16("R4", 16'h0000, 16'h0000);
        chk16("R1", 16'h0001, 16'h0000);
        chk16("R1", 16'h0001, 16'h0001);
        chk16("R4", 16'hBEEF, 16'h0000);
        chk16("R4", 16'h0000, 16'h1234);
        chk16("R5", 16'h5A3C, 16'hA5C3);
        chk16("R5", 16'hFFFF, 16'h0000);
        chk16("R6", 16'hFFFF, 16'hFFFF);
        chk16("R7", 16'hFFFF, 16'h0001);
        chk16("R7", 16'h0001, 16'hFFFF);
        chk16("R8", 16'h5555, 16'hAAAA);
        chk16("R8", 16'hAAAA, 16'hAAAA);
        chk16("R8", 16'h5555, 16'h5555);
        chk16("R3", 16'h8000, 16'h8000);
        chk16("R3", 16'h7FFF, 16'h7FFF);
        chk16("R3", 16'h8000, 16'h7FFF);

        // R9: operands change between clock edges, outputs follow without a clock
        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            int unsigned  kind;
            @(posedge clk);
            #3;
            kind = $urandom % 4;
            x = W'($urandom);
            case (kind)
                0: y = W'($urandom);
                1: y = ~x;
                2: y = ~x ^ (W'(1) << ($urandom % W));
                default: y = x;
            endcase
            chk16(kind == 0 ? "R2" : (kind == 3 ? "R3" : "R9"), x, y);
        end

        // R2: exhaustive 8-bit space, 9-bit result
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 256; k++) begin
                logic [W8:0] exp8;
                a8 = W8'(i);
                b8 = W8'(k);
                #1;
                exp8 = ref8(W8'(i), W8'(k));
                checks++;
                if ({c8, s8} !== exp8) begin
                    failures++;
                    $display("FAIL R2 w8 a=%h b=%h actual=%h expected=%h",
                             a8, b8, {c8, s8}, exp8);
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule